// File: doc/BRIEF.md
# Two-Byte-Instruction Multi-Cycle Processor

This block is a small multi-cycle processor with sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. It works on a 256-byte memory addressed by byte. The memory is external, synchronous and single-ported, and returns read data one clock after the address is presented. Each instruction is 16 bits long. The upper nibble is the operation code. The rest holds a register number and either a byte address or two more register numbers. Each instruction takes two consecutive bytes, with the byte at the lower address carrying the upper half.

A controller sequences every instruction through named states. FETCH_HI puts the program counter on the address bus. FETCH_LO puts the next byte address on the bus and latches the upper byte. DECODE latches the lower byte into the instruction register and advances the program counter by two. EXEC carries out the operation. Its exits are EXEC→LOAD_WB for a load, EXEC→HALTED for a halt, and EXEC→FETCH_HI otherwise. LOAD_WB writes the returned byte into a register and goes to FETCH_HI. HALTED is absorbing and is left only by reset. A store whose target is the top byte address also appears on an output port, which gives a memory-mapped output path.

Top module: `tcpu_core`

## Requirements
- R1: While `rst_n` is low, all registers are zero, the program counter takes `start_addr`, `mem_addr` equals `start_addr`, and `halted`, `mem_we` and `io_valid` are 0. A register written before a reset reads as 0 after it.
- R2: A fetch reads the byte at the program counter (the opcode byte, bits 15:8) and then the byte one above it (bits 7:0). The counter then advances by two, wrapping modulo 256 (FE → 00).
- R3: Opcode 1, word 1RXY, loads register R with the memory byte at address XY.
- R4: Opcode 5, word 5RST, writes (register S + register T) mod 256 into register R.
- R5: Opcode 3, word 3RXY, writes register R to address XY with a one-cycle `mem_we` pulse. Writes happen only in EXEC.
- R6: Opcode B, word BRXY, sets the program counter to XY when register R equals register 0. Otherwise execution continues with the next instruction.
- R7: Opcode C halts the processor. `halted` stays 1, `mem_addr` stays constant and no write occurs until reset.
- R8: A store to address FF also drives the stored byte on `io_data`, with `io_valid` high for exactly the one cycle after the write cycle. A store elsewhere does not raise `io_valid`.
- R9: Opcodes 0, 2, 4, 6-A and D-F change no register and no memory, and do not drive the output port.
- R10: States follow FETCH_HI→FETCH_LO→DECODE→EXEC, adding LOAD_WB for loads. A load therefore takes 5 cycles, any other non-halting instruction takes 4, and HALTED is entered 4 cycles after a halt's FETCH_HI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 8 | Program counter value loaded by reset |
| mem_addr | output | 8 | Byte address to memory |
| mem_we | output | 1 | Write enable to memory |
| mem_wdata | output | 8 | Write data to memory |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt has executed |
| io_data | output | 8 | Byte stored to the output address |
| io_valid | output | 1 | One-cycle strobe for `io_data` |

## Verification
The assertions take for granted that `mem_rdata` always carries the byte at the address presented on the previous edge, that `start_addr` is stable while reset is held, and that reset is asserted at time zero. The bench models memory as a registered array with exactly that latency. It changes `start_addr` only while `rst_n` is low. It places each program and its data bytes at non-overlapping addresses, so that no fetch reads a byte that a store has just changed.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int REG_N  = 16;
    localparam int REG_IW = $clog2(REG_N);
    localparam int OPC_W  = 4;
    localparam int INSN_W = OPC_W + 3 * REG_IW;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'hB;
    localparam logic [OPC_W-1:0] OPC_HALT  = 4'hC;

    localparam logic [ADDR_W-1:0] IO_ADDR = '1;

    typedef enum logic [2:0] {
        S_FETCH_HI,
        S_FETCH_LO,
        S_DECODE,
        S_EXEC,
        S_LOAD_WB,
        S_HALTED
    } state_t;
endpackage

// File: rtl/tcpu_regfile.sv
module tcpu_regfile
    import tcpu_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int NREG = REG_N,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    input  logic [IW-1:0] ra_c,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_c,
    output logic [DW-1:0] rd_zero
);
    logic [DW-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rd_a    = regs_q[ra_a];
    assign rd_b    = regs_q[ra_b];
    assign rd_c    = regs_q[ra_c];
    assign rd_zero = regs_q[0];
endmodule

// File: rtl/tcpu_ioport.sv
module tcpu_ioport
    import tcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] io_data,
    output logic              io_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_valid <= 1'b0;
            io_data  <= '0;
        end else begin
            io_valid <= wr_en && (wr_addr == IO_ADDR);
            if (wr_en && (wr_addr == IO_ADDR)) begin
                io_data <= wr_data;
            end
        end
    end

    // R8
    io_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |=> !io_valid);

    // R8
    io_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> ($past(wr_en) && ($past(wr_addr) == IO_ADDR)
                      && (io_data == $past(wr_data))));
endmodule

// File: rtl/tcpu_ctrl.sv
module tcpu_ctrl
    import tcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              halted,
    output logic              rf_we,
    output logic [REG_IW-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [REG_IW-1:0] rf_ra_a,
    output logic [REG_IW-1:0] rf_ra_b,
    output logic [REG_IW-1:0] rf_ra_c,
    input  logic [DATA_W-1:0] rd_a,
    input  logic [DATA_W-1:0] rd_b,
    input  logic [DATA_W-1:0] rd_c,
    input  logic [DATA_W-1:0] rd_zero
);
    state_t              state_q, state_d;
    logic [ADDR_W-1:0]   pc_q;
    logic [DATA_W-1:0]   hi_q;
    logic [INSN_W-1:0]   ir_q;

    logic [OPC_W-1:0]    opc;
    logic [REG_IW-1:0]   f_r, f_s, f_t;
    logic [ADDR_W-1:0]   f_xy;
    logic                jump_take;

    assign opc       = ir_q[INSN_W-1 -: OPC_W];
    assign f_r       = ir_q[3*REG_IW-1 -: REG_IW];
    assign f_s       = ir_q[2*REG_IW-1 -: REG_IW];
    assign f_t       = ir_q[REG_IW-1:0];
    assign f_xy      = ir_q[ADDR_W-1:0];
    assign jump_take = (rd_a == rd_zero);

    assign rf_ra_a = f_r;
    assign rf_ra_b = f_s;
    assign rf_ra_c = f_t;
    assign halted  = (state_q == S_HALTED);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FETCH_HI;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH_HI: state_d = S_FETCH_LO;
            S_FETCH_LO: state_d = S_DECODE;
            S_DECODE:   state_d = S_EXEC;
            S_EXEC: begin
                if (opc == OPC_LOAD) begin
                    state_d = S_LOAD_WB;
                end else if (opc == OPC_HALT) begin
                    state_d = S_HALTED;
                end else begin
                    state_d = S_FETCH_HI;
                end
            end
            S_LOAD_WB:  state_d = S_FETCH_HI;
            S_HALTED:   state_d = S_HALTED;
            default:    state_d = S_FETCH_HI;
        endcase
    end

    // Outputs per state
    always_comb begin
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = rd_a;
        rf_we     = 1'b0;
        rf_waddr  = f_r;
        rf_wdata  = mem_rdata;
        unique case (state_q)
            S_FETCH_LO: mem_addr = pc_q + ADDR_W'(1);
            S_EXEC: begin
                if (opc == OPC_LOAD || opc == OPC_STORE) begin
                    mem_addr = f_xy;
                end
                if (opc == OPC_STORE) begin
                    mem_we = 1'b1;
                end
                if (opc == OPC_ADD) begin
                    rf_we    = 1'b1;
                    rf_wdata = rd_b + rd_c;
                end
            end
            S_LOAD_WB: begin
                mem_addr = f_xy;
                rf_we    = 1'b1;
                rf_wdata = mem_rdata;
            end
            default: ;
        endcase
    end

    // Program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= start_addr;
            hi_q <= '0;
            ir_q <= '0;
        end else begin
            unique case (state_q)
                S_FETCH_LO: hi_q <= mem_rdata;
                S_DECODE: begin
                    ir_q <= {hi_q, mem_rdata};
                    pc_q <= pc_q + ADDR_W'(2);
                end
                S_EXEC: begin
                    if (opc == OPC_JUMP && jump_take) begin
                        pc_q <= f_xy;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE) |=> (pc_q == $past(pc_q) + ADDR_W'(2)));

    // R2
    lo_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH_LO) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R10
    fetch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH_HI) |=> (state_q == S_FETCH_LO));

    // R5
    we_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state_q == S_EXEC));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALTED) |=> ((state_q == S_HALTED) && $stable(pc_q)));
endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
    import tcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [DATA_W-1:0] io_data,
    output logic              io_valid
);
    logic              rf_we;
    logic [REG_IW-1:0] rf_waddr, rf_ra_a, rf_ra_b, rf_ra_c;
    logic [DATA_W-1:0] rf_wdata, rd_a, rd_b, rd_c, rd_zero;

    tcpu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .halted     (halted),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .rf_ra_a    (rf_ra_a),
        .rf_ra_b    (rf_ra_b),
        .rf_ra_c    (rf_ra_c),
        .rd_a       (rd_a),
        .rd_b       (rd_b),
        .rd_c       (rd_c),
        .rd_zero    (rd_zero)
    );

    tcpu_regfile #(.DW(DATA_W), .NREG(REG_N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .ra_a    (rf_ra_a),
        .ra_b    (rf_ra_b),
        .ra_c    (rf_ra_c),
        .rd_a    (rd_a),
        .rd_b    (rd_b),
        .rd_c    (rd_c),
        .rd_zero (rd_zero)
    );

    tcpu_ioport u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mem_we),
        .wr_addr  (mem_addr),
        .wr_data  (mem_wdata),
        .io_data  (io_data),
        .io_valid (io_valid)
    );

    // R7
    halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
endmodule

// File: tb/tcpu_core_bench.sv
`timescale 1ns/1ps
module tcpu_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] start_addr = 8'hA0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, io_data;
    logic       mem_we, halted, io_valid;

    logic [7:0] mem [256];
    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int io_cnt = 0;
    logic [7:0] io_last = 8'h00;

    always #2.5 clk = ~clk;

    tcpu_core u_tcpu_core (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .halted(halted),
        .io_data(io_data), .io_valid(io_valid)
    );

    // Registered single-port memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (rst_n && io_valid) begin
            io_cnt  = io_cnt + 1;
            io_last = io_data;
        end
    end

    // add operand a, operand b, expected sum
    localparam logic [23:0] VEC [6] = '{
        24'h01_02_03, 24'h7F_01_80, 24'hFF_01_00,
        24'h80_80_00, 24'hFF_FF_FE, 24'h00_00_00
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wr_cnt = 0;
        io_cnt = 0;
        io_last = 8'h00;
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] w);
        mem[a] = w[15:8];
        mem[8'(a + 8'd1)] = w[7:0];
    endtask

    task automatic do_reset(input logic [7:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        start_addr = s;
        repeat (2) @(negedge clk);
        wr_cnt = 0;
        io_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic run(output int cyc);
        cyc = 0;
        while (!halted && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk(halted, "R7 halt reached", halted, 1);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [7:0] a0;
        bit ok;

        // R1 reset state
        clear_mem();
        rst_n = 1'b0;
        start_addr = 8'h5A;
        repeat (3) @(negedge clk);
        chk(mem_addr == 8'h5A, "R1 reset addr", mem_addr, 8'h5A);
        chk(halted == 1'b0, "R1 reset halted", halted, 0);
        chk(io_valid == 1'b0, "R1 reset io_valid", io_valid, 0);
        chk(mem_we == 1'b0, "R1 reset mem_we", mem_we, 0);

        // R2 fetch order and pc wrap from FE, with a nop (R9)
        clear_mem();
        put(8'hFE, 16'h2000);
        put(8'h00, 16'hC000);
        do_reset(8'hFE);
        chk(mem_addr == 8'hFE, "R2 fetch hi addr", mem_addr, 8'hFE);
        @(negedge clk);
        chk(mem_addr == 8'hFF, "R2 fetch lo addr", mem_addr, 8'hFF);
        @(negedge clk);
        @(negedge clk);
        chk(mem_addr == 8'h00, "R2 pc wrap +2", mem_addr, 8'h00);
        run(cyc);
        chk(wr_cnt == 0, "R9 nop no write", wr_cnt, 0);

        // Vector table: load, load, add, store, halt (R3 R4 R5)
        for (int i = 0; i < 6; i++) begin
            clear_mem();
            put(8'hA0, 16'h156C);
            put(8'hA2, 16'h166D);
            put(8'hA4, 16'h5056);
            put(8'hA6, 16'h306E);
            put(8'hA8, 16'hC000);
            mem[8'h6C] = VEC[i][23:16];
            mem[8'h6D] = VEC[i][15:8];
            do_reset(8'hA0);
            run(cyc);
            chk(mem[8'h6E] == VEC[i][7:0], "R4 add wrap", mem[8'h6E], VEC[i][7:0]);
            chk(wr_cnt == 1, "R5 single store", wr_cnt, 1);
        end

        // R3 load then store, R10 cycle count
        clear_mem();
        put(8'hA0, 16'h1730);
        put(8'hA2, 16'h3731);
        put(8'hA4, 16'hC000);
        mem[8'h30] = 8'hA5;
        do_reset(8'hA0);
        run(cyc);
        chk(mem[8'h31] == 8'hA5, "R3 load value", mem[8'h31], 8'hA5);
        chk(cyc == 13, "R10 state cycle count", cyc, 13);

        // R6 conditional jump
        clear_mem();
        put(8'hA0, 16'h1140);
        put(8'hA2, 16'hB1B0);
        put(8'hA4, 16'h3150);
        put(8'hA6, 16'h1041);
        put(8'hA8, 16'hB1C0);
        put(8'hAA, 16'h3151);
        put(8'hAC, 16'hC000);
        put(8'hC0, 16'h3152);
        put(8'hC2, 16'hC000);
        mem[8'h40] = 8'h07;
        mem[8'h41] = 8'h07;
        do_reset(8'hA0);
        run(cyc);
        chk(mem[8'h50] == 8'h07, "R6 not taken falls through", mem[8'h50], 8'h07);
        chk(mem[8'h51] == 8'h00, "R6 taken skips", mem[8'h51], 8'h00);
        chk(mem[8'h52] == 8'h07, "R6 taken target", mem[8'h52], 8'h07);

        // R9 unused opcodes
        clear_mem();
        put(8'hA0, 16'h1140);
        put(8'hA2, 16'h2123);
        put(8'hA4, 16'h0000);
        put(8'hA6, 16'hF1FF);
        put(8'hA8, 16'h3150);
        put(8'hAA, 16'hC000);
        mem[8'h40] = 8'h5A;
        do_reset(8'hA0);
        run(cyc);
        chk(mem[8'h50] == 8'h5A, "R9 register untouched", mem[8'h50], 8'h5A);
        chk(wr_cnt == 1, "R9 no extra write", wr_cnt, 1);
        chk(io_cnt == 0, "R9 no io", io_cnt, 0);

        // R8 memory-mapped output
        clear_mem();
        put(8'hA0, 16'h1140);
        put(8'hA2, 16'h31FF);
        put(8'hA4, 16'h3142);
        put(8'hA6, 16'hC000);
        mem[8'h40] = 8'h3C;
        do_reset(8'hA0);
        run(cyc);
        chk(io_cnt == 1, "R8 one strobe", io_cnt, 1);
        chk(io_last == 8'h3C, "R8 io data", io_last, 8'h3C);
        chk(mem[8'hFF] == 8'h3C, "R8 memory also written", mem[8'hFF], 8'h3C);
        chk(mem[8'h42] == 8'h3C, "R5 plain store", mem[8'h42], 8'h3C);

        // R7 halted holds
        a0 = mem_addr;
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!halted || mem_addr != a0) ok = 1'b0;
        end
        chk(ok, "R7 halted stable", ok, 1);
        chk(wr_cnt == 2, "R7 no write after halt", wr_cnt, 2);

        // R1 registers cleared by reset
        clear_mem();
        put(8'hA0, 16'h1340);
        put(8'hA2, 16'hC000);
        put(8'hB0, 16'h3360);
        put(8'hB2, 16'hC000);
        mem[8'h40] = 8'h55;
        mem[8'h60] = 8'hAA;
        do_reset(8'hA0);
        run(cyc);
        do_reset(8'hB0);
        run(cyc);
        chk(mem[8'h60] == 8'h00, "R1 register cleared", mem[8'h60], 8'h00);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule